// File: doc/BRIEF.md
# I2C Register Target with Persistent Auto-Increment Pointer

This block is the I2C target side of a small register space. It watches an SCL/SDA pair that it samples with its own system clock, frames transfers on start and stop conditions, and answers only to the 7-bit address 0001110. The eighth bit of the address byte gives the direction: 0 for a write, 1 for a read. On a write, the first byte after the address loads an internal 8-bit register pointer. Each later byte is written to the register that the pointer selects, and the pointer then advances by one. On a read, bytes are returned from the pointer location, and the pointer advances after each byte.

The pointer is kept across stop conditions and repeated starts. A read that is not preceded by a pointer write therefore continues from wherever the last transfer left off. The usual "set pointer, repeated start, read L bytes" sequence returns registers M through M+L-1. The register storage itself sits outside the block, behind a plain read/write port. The read data is combinational from the pointer address, and the write is a one-cycle strobe.

The SDA output is open-drain. `sda_oe` high means the block pulls SDA low, and `sda_oe` low means it releases the line.

Top module: `i2c_regs_target`

## Requirements
- R1: After the eighth bit of an address byte whose top seven bits are 0001110, `sda_oe` stays low until the SCL falling edge that follows that eighth bit. It is high from that edge until the next SCL falling edge, and then low again when the transfer is a write.
- R2: When the address bits differ from 0001110, `sda_oe` stays low and `rf_wr_en` never pulses until the next start or stop. The pointer (`rf_addr`) is unchanged by the bytes that follow.
- R3: In a write transfer, the first byte after the address loads the pointer. Each following byte is written with one `rf_wr_en` pulse to the register at the current pointer, and the pointer then becomes pointer+1. Every byte received in a matched write is acknowledged.
- R4: A read transfer with no pointer write before it returns first the register at the current pointer value.
- R5: Read data is sent MSB first, with each bit placed on SDA after an SCL falling edge. After L bytes are read from pointer K, the pointer is K+L.
- R6: Writing pointer M, then a repeated start with the read bit set, then reading L bytes returns the registers M through M+L-1 in that order.
- R7: After the master answers a read byte with NACK (SDA high on the ninth clock), `sda_oe` stays low on later SCL clocks, and the pointer does not move, until a start or stop.
- R8: A stop condition (SDA rising while SCL is high) returns the block to idle and leaves the pointer unchanged. A byte cut short by a stop is not written.
- R9: The pointer wraps from 0xFF to 0x00 in both write and read bursts.
- R10: After reset, `sda_oe` is low, `rf_wr_en` is low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples SCL and SDA |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_in | input | 1 | Sampled SCL line level |
| sda_in | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| rf_addr | output | PTR_W (8) | Register pointer, address for both reads and writes |
| rf_wr_en | output | 1 | One-cycle write strobe for the register at `rf_addr` |
| rf_wr_data | output | 8 | Byte to write when `rf_wr_en` is high |
| rf_rd_data | input | 8 | Contents of the register at `rf_addr` |

## Verification
An SCL or SDA edge at the pins reaches the control logic after the two synchronizer flops and the edge-detect register. A change of `sda_oe` follows about four system clocks after the SCL edge that causes it, and the write strobe lands on the same detected edge, before the ACK is driven. The bench runs the bus with a quarter-period of ten system clocks. It samples `sda_oe` and the SDA line at negative clock edges, either in the middle of an SCL high phase or ten clocks after an SCL fall, so every expected value has settled with several cycles of margin. Pointer and register contents are read only after a stop or at a later byte boundary, which is long after the final strobe.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  localparam int BYTE_W = 8;
  localparam int DEVA_W = 7;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_PTR,
    ST_PTR_ACK,
    ST_WDATA,
    ST_WDATA_ACK,
    ST_RDATA,
    ST_RD_ACK,
    ST_WAIT
  } tgt_state_t;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_in,
  input  logic sda_in,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);

  localparam int LINES = 2;

  logic [LINES-1:0]  raw;
  logic [STAGES-1:0] chain [LINES];
  logic              scl_q;
  logic              sda_q;

  assign raw = {scl_in, sda_in};

  generate
    for (genvar l = 0; l < LINES; l++) begin : g_line
      logic [STAGES-1:0] chain_d;
      if (STAGES == 1) begin : g_one
        assign chain_d = raw[l];
      end else begin : g_many
        assign chain_d = {chain[l][STAGES-2:0], raw[l]};
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain[l] <= '1;
        end else begin
          chain[l] <= chain_d;
        end
      end
    end
  endgenerate

  assign scl_s = chain[1][STAGES-1];
  assign sda_s = chain[0][STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/i2c_tgt_ptr.sv
module i2c_tgt_ptr #(
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             inc,
  input  logic [PTR_W-1:0] load_val,
  output logic [PTR_W-1:0] ptr
);

  logic [PTR_W-1:0] ptr_d;

  always_comb begin
    ptr_d = ptr;
    if (load) begin
      ptr_d = load_val;
    end else if (inc) begin
      ptr_d = ptr + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr <= '0;
    end else if (load || inc) begin
      ptr <= ptr_d;
    end
  end

  // R9: a step from all ones lands on zero
  assert_ptr_wrap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load && ptr == '1) |=> (ptr == '0));

  // R8: without a load or a step the pointer holds
  assert_ptr_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !inc) |=> $stable(ptr));

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [DEVA_W-1:0] DEV_ADDR = 7'b0001110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic              ptr_load,
  output logic              ptr_inc,
  output logic [BYTE_W-1:0] shreg
);

  localparam logic [CNT_W-1:0] FULL = CNT_W'(BYTE_W);

  tgt_state_t        state_q, state_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [BYTE_W-1:0] sh_q, sh_d;
  logic              oe_q, oe_d;
  logic              rw_q, rw_d;
  logic              mack_q, mack_d;

  always_comb begin
    state_d  = state_q;
    cnt_d    = cnt_q;
    sh_d     = sh_q;
    oe_d     = oe_q;
    rw_d     = rw_q;
    mack_d   = mack_q;
    wr_en    = 1'b0;
    ptr_load = 1'b0;
    ptr_inc  = 1'b0;
    if (stop_det) begin
      state_d = ST_IDLE;
      oe_d    = 1'b0;
    end else if (start_det) begin
      state_d = ST_ADDR;
      cnt_d   = '0;
      oe_d    = 1'b0;
    end else begin
      unique case (state_q)
        ST_ADDR, ST_PTR, ST_WDATA: begin
          if (scl_rise && cnt_q != FULL) begin
            sh_d  = {sh_q[BYTE_W-2:0], sda_s};
            cnt_d = cnt_q + 1'b1;
          end else if (scl_fall && cnt_q == FULL) begin
            cnt_d = '0;
            if (state_q == ST_ADDR) begin
              if (sh_q[BYTE_W-1:1] == DEV_ADDR) begin
                state_d = ST_ADDR_ACK;
                oe_d    = 1'b1;
                rw_d    = sh_q[0];
              end else begin
                state_d = ST_WAIT;
              end
            end else if (state_q == ST_PTR) begin
              ptr_load = 1'b1;
              state_d  = ST_PTR_ACK;
              oe_d     = 1'b1;
            end else begin
              wr_en   = 1'b1;
              ptr_inc = 1'b1;
              state_d = ST_WDATA_ACK;
              oe_d    = 1'b1;
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            if (rw_q) begin
              state_d = ST_RDATA;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = CNT_W'(1);
            end else begin
              state_d = ST_PTR;
              oe_d    = 1'b0;
              cnt_d   = '0;
            end
          end
        end
        ST_PTR_ACK, ST_WDATA_ACK: begin
          if (scl_fall) begin
            state_d = ST_WDATA;
            oe_d    = 1'b0;
            cnt_d   = '0;
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt_q == FULL) begin
              state_d = ST_RD_ACK;
              oe_d    = 1'b0;
            end else begin
              oe_d  = ~sh_q[BYTE_W-2];
              sh_d  = {sh_q[BYTE_W-2:0], 1'b0};
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            ptr_inc = 1'b1;
            mack_d  = ~sda_s;
          end else if (scl_fall) begin
            if (mack_q) begin
              state_d = ST_RDATA;
              sh_d    = rd_data;
              oe_d    = ~rd_data[BYTE_W-1];
              cnt_d   = CNT_W'(1);
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      oe_q    <= 1'b0;
      rw_q    <= 1'b0;
      mack_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      oe_q    <= oe_d;
      rw_q    <= rw_d;
      mack_q  <= mack_d;
    end
  end

  assign sda_oe = oe_q;
  assign shreg  = sh_q;

  // R2 / R7: a quiet wait never pulls the line
  assert_wait_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT) |-> !oe_q);

  // R1: the drive changes only while SCL is low, apart from framing events
  assert_oe_on_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(oe_q) |-> (!scl_s || $past(start_det || stop_det)));

  // R8: a stop lands in idle with the line released
  assert_stop_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> (state_q == ST_IDLE && !oe_q));

  // R3: a register write never coincides with the block driving SDA
  assert_write_released_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> !oe_q);

  // R5: a read byte ends with the line released for the master's answer
  assert_read_ack_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RD_ACK) |-> !oe_q);

endmodule

// File: rtl/i2c_regs_target.sv
module i2c_regs_target
  import i2c_tgt_pkg::*;
#(
  parameter int                PTR_W       = 8,
  parameter int                SYNC_STAGES = 2,
  parameter logic [DEVA_W-1:0] DEV_ADDR    = 7'b0001110
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  output logic              sda_oe,
  output logic [PTR_W-1:0]  rf_addr,
  output logic              rf_wr_en,
  output logic [BYTE_W-1:0] rf_wr_data,
  input  logic [BYTE_W-1:0] rf_rd_data
);

  logic rst_meta;
  logic rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_n_s  <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_n_s  <= rst_meta;
    end
  end

  logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic ptr_load, ptr_inc;
  logic [BYTE_W-1:0] shreg;

  i2c_line_sync #(
    .STAGES(SYNC_STAGES)
  ) u_sync (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_in   (scl_in),
    .sda_in   (sda_in),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det)
  );

  i2c_tgt_fsm #(
    .DEV_ADDR(DEV_ADDR)
  ) u_fsm (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .scl_s    (scl_s),
    .sda_s    (sda_s),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_det(start_det),
    .stop_det (stop_det),
    .rd_data  (rf_rd_data),
    .sda_oe   (sda_oe),
    .wr_en    (rf_wr_en),
    .ptr_load (ptr_load),
    .ptr_inc  (ptr_inc),
    .shreg    (shreg)
  );

  logic [PTR_W-1:0] ptr_val;

  generate
    if (PTR_W > BYTE_W) begin : g_wide
      assign ptr_val = {{(PTR_W-BYTE_W){1'b0}}, shreg};
    end else begin : g_narrow
      assign ptr_val = shreg[PTR_W-1:0];
    end
  endgenerate

  i2c_tgt_ptr #(
    .PTR_W(PTR_W)
  ) u_ptr (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .load    (ptr_load),
    .inc     (ptr_inc),
    .load_val(ptr_val),
    .ptr     (rf_addr)
  );

  assign rf_wr_data = shreg;

endmodule

// File: tb/i2c_regs_target_test.sv
`timescale 1ns/1ps
module i2c_regs_target_test;

  localparam int Q = 10;

  logic clk;
  logic rst_n;
  logic scl_m;
  logic sda_m;
  logic sda_line;
  logic sda_oe;
  logic [7:0] rf_addr;
  logic rf_wr_en;
  logic [7:0] rf_wr_data;
  logic [7:0] rf_rd_data;

  int n_checks;
  int n_fail;
  int wr_count;
  int oe_hits;

  logic [7:0] mem [256];

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  assign sda_line = sda_m & ~sda_oe;

  i2c_regs_target uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_in    (scl_m),
    .sda_in    (sda_line),
    .sda_oe    (sda_oe),
    .rf_addr   (rf_addr),
    .rf_wr_en  (rf_wr_en),
    .rf_wr_data(rf_wr_data),
    .rf_rd_data(rf_rd_data)
  );

  function automatic logic [7:0] seed(input int i);
    return 8'(i) ^ 8'h3C;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= seed(i);
    end else if (rf_wr_en) begin
      mem[rf_addr] <= rf_wr_data;
    end
  end

  assign rf_rd_data = mem[rf_addr];

  always @(negedge clk) begin
    if (!rst_n) begin
      wr_count <= 0;
    end else begin
      if (rf_wr_en) wr_count <= wr_count + 1;
      if (sda_oe) oe_hits <= oe_hits + 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(Q);
    sda_m = 1'b1; tick(Q);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q);
    scl_m = 1'b1; tick(Q);
    b = sda_line; tick(Q);
    scl_m = 1'b0; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output logic acked);
    logic b;
    for (int i = 7; i >= 0; i--) put_bit(d[i]);
    get_bit(b);
    acked = ~b;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] d);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      d[i] = b;
    end
    put_bit(~give_ack);
  endtask

  task automatic t_reset();
    chk("R10 sda_oe after reset", sda_oe, 1'b0);
    chk("R10 pointer after reset", rf_addr, 8'h00);
    chk("R10 writes after reset", wr_count, 0);
  endtask

  task automatic t_ack_and_write();
    logic a;
    logic b;
    bus_start();
    for (int i = 7; i >= 1; i--) put_bit(1'(8'h1C >> i));
    sda_m = 1'b0; tick(Q);
    scl_m = 1'b1; tick(2 * Q);
    chk("R1 no ack before 8th fall", sda_oe, 1'b0);
    scl_m = 1'b0; tick(Q);
    chk("R1 ack driven after 8th fall", sda_oe, 1'b1);
    get_bit(b);
    chk("R1 line low during ack clock", b, 1'b0);
    chk("R1 released after 9th fall", sda_oe, 1'b0);
    send_byte(8'h10, a); chk("R3 pointer byte acked", a, 1'b1);
    send_byte(8'hA5, a); chk("R3 data byte acked", a, 1'b1);
    send_byte(8'h5A, a);
    bus_stop(); tick(Q);
    chk("R3 first data at pointer", mem[8'h10], 8'hA5);
    chk("R3 second data at pointer+1", mem[8'h11], 8'h5A);
    chk("R3 pointer after burst", rf_addr, 8'h12);
    chk("R3 write strobes", wr_count, 2);
  endtask

  task automatic t_read_current();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'h1D, a); chk("R4 read address acked", a, 1'b1);
    recv_byte(1'b0, d);
    bus_stop(); tick(Q);
    chk("R4 data from current pointer", d, seed(8'h12));
    chk("R5 pointer after one read", rf_addr, 8'h13);
  endtask

  task automatic t_seq_read();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'h1C, a);
    send_byte(8'h40, a);
    bus_start();
    send_byte(8'h1D, a); chk("R6 read after repeated start acked", a, 1'b1);
    for (int k = 0; k < 4; k++) begin
      recv_byte(k != 3, d);
      chk("R6 sequential byte", d, seed(8'h40 + k));
    end
    bus_stop(); tick(Q);
    chk("R5 pointer after four reads", rf_addr, 8'h44);
  endtask

  task automatic t_nack();
    logic a;
    logic b;
    logic [7:0] d;
    bus_start();
    send_byte(8'h1D, a);
    recv_byte(1'b0, d);
    chk("R7 byte before nack", d, seed(8'h44));
    oe_hits = 0;
    for (int i = 0; i < 9; i++) begin
      get_bit(b);
      chk("R7 line idle after nack", b, 1'b1);
    end
    chk("R7 no drive after nack", oe_hits, 0);
    bus_stop(); tick(Q);
    chk("R7 pointer frozen after nack", rf_addr, 8'h45);
  endtask

  task automatic t_mismatch();
    logic a;
    int w0;
    w0 = wr_count;
    oe_hits = 0;
    bus_start();
    send_byte(8'h1E, a); chk("R2 foreign address not acked", a, 1'b0);
    send_byte(8'h20, a); chk("R2 later byte not acked", a, 1'b0);
    send_byte(8'h99, a);
    bus_stop(); tick(Q);
    chk("R2 never drove sda", oe_hits, 0);
    chk("R2 no writes", wr_count, w0);
    chk("R2 pointer untouched", rf_addr, 8'h45);
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] d;
    bus_start();
    send_byte(8'h1C, a);
    send_byte(8'hFE, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop(); tick(Q);
    chk("R9 write at FE", mem[8'hFE], 8'h11);
    chk("R9 write at FF", mem[8'hFF], 8'h22);
    chk("R9 write wrapped to 00", mem[8'h00], 8'h33);
    chk("R9 pointer after write wrap", rf_addr, 8'h01);
    bus_start();
    send_byte(8'h1C, a);
    send_byte(8'hFF, a);
    bus_stop(); tick(Q);
    chk("R8 pointer kept over stop", rf_addr, 8'hFF);
    bus_start();
    send_byte(8'h1D, a);
    recv_byte(1'b1, d); chk("R9 read at FF", d, 8'h22);
    recv_byte(1'b0, d); chk("R9 read wrapped to 00", d, 8'h33);
    bus_stop(); tick(Q);
    chk("R9 pointer after read wrap", rf_addr, 8'h01);
  endtask

  task automatic t_stop_mid();
    logic a;
    logic [7:0] d;
    int w0;
    w0 = wr_count;
    bus_start();
    send_byte(8'h1C, a);
    send_byte(8'h80, a);
    put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
    bus_stop(); tick(Q);
    chk("R8 partial byte not written", wr_count, w0);
    chk("R8 pointer after cut byte", rf_addr, 8'h80);
    bus_start();
    send_byte(8'h1D, a);
    recv_byte(1'b0, d);
    bus_stop(); tick(Q);
    chk("R8 register intact after cut byte", d, seed(8'h80));
  endtask

  initial begin
    n_checks = 0;
    n_fail   = 0;
    oe_hits  = 0;
    scl_m    = 1'b1;
    sda_m    = 1'b1;
    rst_n    = 1'b0;
    tick(5);
    rst_n = 1'b1;
    tick(5);
    t_reset();
    t_ack_and_write();
    t_read_current();
    t_seq_read();
    t_nack();
    t_mismatch();
    t_wrap();
    t_stop_mid();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: all requirements, actual hung expected done");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

endmodule